// File: doc/BRIEF.md
# CAN Receive Buffer Controller

This block sits between the frame assembler of a CAN receiver and the processor. A frame is assembled in a hidden staging buffer that keeps listening to the bus. When the assembler reports a complete frame that the identifier filter has accepted, this block copies it into one of two buffers the processor can read. The filter's result picks the buffer. Each readable buffer has a full flag, which also serves as its receive flag, and a sticky overrun flag. A shared error flag records any overrun. A single interrupt line combines the enabled receive flags with the error flag.

Frames can spill over from buffer 0 into buffer 1 when the rollover option is on. When it is off, the two buffers work independently of each other. The processor frees a buffer by pulsing its clear strobe. A clear that arrives in the same clock as a new frame counts as done before that frame is placed.

Top module: `can_rx_buf_ctrl`

## Requirements
- R1: After reset, every full flag, overrun flag, the error flag and the interrupt are 0, and both buffer contents are 0.
- R2: A frame is stored only when `frame_vld_i` and `accept_hit_i` are both 1 at a clock edge. Otherwise no flag and no buffer content changes.
- R3: An accepted frame with `tgt_sel_i`=0 goes to buffer 0, and one with `tgt_sel_i`=1 goes to buffer 1. The target must be empty. The data is then visible and the full bit (bit k of `rx_full_o` for buffer k) is 1 one clock later. Buffer k occupies bits [k*DATA_W +: DATA_W] of `buf_data_o`.
- R4: A pulse on `rx_clr_i[k]` clears full bit k on the next clock, which makes buffer k empty again.
- R5: An accepted frame whose target buffer is full is discarded. The target's overrun bit and `err_o` are set, and the buffer contents stay unchanged.
- R6: With `rollover_en_i`=0, a frame for a full buffer 0 is never written to buffer 1.
- R7: With `rollover_en_i`=1, a frame for buffer 0 is stored in buffer 1 when buffer 0 is full and buffer 1 is empty. No overrun is flagged on buffer 0.
- R8: With `rollover_en_i`=1, a frame for buffer 0 arriving while both buffers are full is dropped. The overrun bit of buffer 1 and `err_o` are set.
- R9: When `rx_clr_i[k]` and an accepted frame for buffer k arrive in the same cycle, the frame is stored and no overrun is flagged.
- R10: Overrun bits and `err_o` hold until their clear strobe (`ovr_clr_i[k]`, `err_clr_i`). A new overrun in the same cycle as a clear leaves the flag set.
- R11: `irq_o` is 1 whenever, for some buffer k, both `rx_full_o[k]` and `irq_en_i[k]` are 1, or whenever `err_o` is 1.
- R12: A frame for buffer 1 arriving while buffer 1 is full overruns buffer 1, whatever the setting of `rollover_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | Staging buffer holds a complete frame (one-cycle strobe) |
| accept_hit_i | input | 1 | Identifier filter accepted the frame |
| tgt_sel_i | input | 1 | Filter-selected buffer: 0 or 1 |
| frame_data_i | input | DATA_W | Frame contents from the staging buffer |
| rollover_en_i | input | 1 | Allows spill from buffer 0 into buffer 1 |
| irq_en_i | input | 2 | Per-buffer receive interrupt enable |
| rx_clr_i | input | 2 | Processor done with buffer k (frees it) |
| ovr_clr_i | input | 2 | Clears the overrun bit of buffer k |
| err_clr_i | input | 1 | Clears the error flag |
| buf_data_o | output | 2*DATA_W | Buffer contents, buffer 0 in the low half |
| rx_full_o | output | 2 | Full / receive flag per buffer |
| ovr_o | output | 2 | Sticky overrun flag per buffer |
| err_o | output | 1 | Sticky error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Buffer contents, full bits, overrun bits and the error flag are all registered. Each is due exactly one clock after the edge that sees the frame or the strobe. `irq_o` is combinational from those registers and from `irq_en_i`, so it is due in the same cycle as the flags it combines. The bench changes inputs on the falling edge, lets one rising edge pass, and compares every output on the following falling edge, before it drives the next stimulus. Rows for same-cycle clear-and-frame and for set-versus-clear collisions check the ordering within a single edge.

// File: rtl/can_rx_buf_pkg.sv
package can_rx_buf_pkg;
  localparam int unsigned NBUF = 2;
  localparam int unsigned BUF0 = 0;
  localparam int unsigned BUF1 = 1;
  typedef logic [NBUF-1:0] buf_vec_t;
endpackage

// File: rtl/can_rx_route.sv
module can_rx_route
  import can_rx_buf_pkg::*;
(
  input  logic     take_i,
  input  logic     tgt_i,
  input  logic     roll_i,
  input  buf_vec_t busy_i,
  output buf_vec_t load_o,
  output buf_vec_t ovr_set_o
);
  always_comb begin
    load_o    = '0;
    ovr_set_o = '0;
    if (take_i) begin
      if (tgt_i) begin
        if (!busy_i[BUF1]) load_o[BUF1]    = 1'b1;
        else               ovr_set_o[BUF1] = 1'b1;
      end else if (!busy_i[BUF0]) begin
        load_o[BUF0] = 1'b1;
      end else if (roll_i && !busy_i[BUF1]) begin
        load_o[BUF1] = 1'b1;           // spill, no overrun on buffer 0
      end else if (roll_i) begin
        ovr_set_o[BUF1] = 1'b1;        // both full: report on buffer 1
      end else begin
        ovr_set_o[BUF0] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              ovr_set_i,
  input  logic              rx_clr_i,
  input  logic              ovr_clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      data_o <= '0;
    end else begin
      if (load_i)        full_o <= 1'b1;
      else if (rx_clr_i) full_o <= 1'b0;
      if (load_i)        data_o <= data_i;
      if (ovr_set_i)      ovr_o <= 1'b1;   // set wins over clear
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_rx_irq.sv
module can_rx_irq
  import can_rx_buf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     err_set_i,
  input  logic     err_clr_i,
  input  buf_vec_t full_i,
  input  buf_vec_t en_i,
  output logic     err_o,
  output logic     irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (err_set_i) err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end

  assign irq_o = (|(full_i & en_i)) | err_o;
endmodule

// File: rtl/can_rx_buf_ctrl.sv
module can_rx_buf_ctrl
  import can_rx_buf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_vld_i,
  input  logic                   accept_hit_i,
  input  logic                   tgt_sel_i,
  input  logic [DATA_W-1:0]      frame_data_i,
  input  logic                   rollover_en_i,
  input  logic [NBUF-1:0]        irq_en_i,
  input  logic [NBUF-1:0]        rx_clr_i,
  input  logic [NBUF-1:0]        ovr_clr_i,
  input  logic                   err_clr_i,
  output logic [NBUF*DATA_W-1:0] buf_data_o,
  output logic [NBUF-1:0]        rx_full_o,
  output logic [NBUF-1:0]        ovr_o,
  output logic                   err_o,
  output logic                   irq_o
);
  buf_vec_t busy, load, ovr_set;
  logic     take;

  assign take = frame_vld_i & accept_hit_i;
  // a clear in the same cycle frees the buffer for the arriving frame
  assign busy = rx_full_o & ~rx_clr_i;

  can_rx_route u_route (
    .take_i    (take),
    .tgt_i     (tgt_sel_i),
    .roll_i    (rollover_en_i),
    .busy_i    (busy),
    .load_o    (load),
    .ovr_set_o (ovr_set)
  );

  for (genvar k = 0; k < NBUF; k++) begin : g_slot
    can_rx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[k]),
      .ovr_set_i (ovr_set[k]),
      .rx_clr_i  (rx_clr_i[k]),
      .ovr_clr_i (ovr_clr_i[k]),
      .data_i    (frame_data_i),
      .full_o    (rx_full_o[k]),
      .ovr_o     (ovr_o[k]),
      .data_o    (buf_data_o[k*DATA_W +: DATA_W])
    );
  end

  can_rx_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_set_i (|ovr_set),
    .err_clr_i (err_clr_i),
    .full_i    (rx_full_o),
    .en_i      (irq_en_i),
    .err_o     (err_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/can_rx_buf_ctrl_chk.sv
module can_rx_buf_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_vld_i,
  input logic                accept_hit_i,
  input logic                tgt_sel_i,
  input logic [DATA_W-1:0]   frame_data_i,
  input logic                rollover_en_i,
  input logic [1:0]          irq_en_i,
  input logic [1:0]          rx_clr_i,
  input logic [1:0]          ovr_clr_i,
  input logic                err_clr_i,
  input logic [2*DATA_W-1:0] buf_data_o,
  input logic [1:0]          rx_full_o,
  input logic [1:0]          ovr_o,
  input logic                err_o,
  input logic                irq_o
);
  logic              take;
  logic [1:0]        busy;
  logic [DATA_W-1:0] d0, d1;
  assign take = frame_vld_i & accept_hit_i;
  assign busy = rx_full_o & ~rx_clr_i;
  assign d0   = buf_data_o[DATA_W-1:0];
  assign d1   = buf_data_o[2*DATA_W-1:DATA_W];

  p_full_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o[0]) |-> $past(take));

  p_load1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && tgt_sel_i && !busy[1] |=> rx_full_o[1] && d1 == $past(frame_data_i));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i[0] && !take |=> !rx_full_o[0]);

  p_ovr0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tgt_sel_i && !rollover_en_i && busy[0] |=> ovr_o[0] && err_o && $stable(d0));

  p_no_spill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tgt_sel_i && !rollover_en_i |=> $stable(d1) || $past(d1) == $past(frame_data_i));

  p_spill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tgt_sel_i && rollover_en_i && busy[0] && !busy[1]
    |=> rx_full_o[1] && d1 == $past(frame_data_i)
        && ovr_o[0] == ($past(ovr_o[0]) && !$past(ovr_clr_i[0])));

  p_both_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tgt_sel_i && rollover_en_i && busy[0] && busy[1]
    |=> ovr_o[1] && err_o && $stable(d0) && $stable(d1));

  p_same_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tgt_sel_i && rx_clr_i[0] |=> rx_full_o[0] && d0 == $past(frame_data_i));

  p_ovr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o[1] && !ovr_clr_i[1] |=> ovr_o[1]);

  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);

  p_err_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> irq_o);

  p_ovr1_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && tgt_sel_i && busy[1] |=> ovr_o[1] && err_o && $stable(d1));
endmodule

bind can_rx_buf_ctrl can_rx_buf_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_vld_i(frame_vld_i),
  .accept_hit_i(accept_hit_i), .tgt_sel_i(tgt_sel_i), .frame_data_i(frame_data_i),
  .rollover_en_i(rollover_en_i), .irq_en_i(irq_en_i), .rx_clr_i(rx_clr_i),
  .ovr_clr_i(ovr_clr_i), .err_clr_i(err_clr_i), .buf_data_o(buf_data_o),
  .rx_full_o(rx_full_o), .ovr_o(ovr_o), .err_o(err_o), .irq_o(irq_o)
);

// File: tb/can_rx_buf_ctrl_tb.sv
`timescale 1ns/1ps
module can_rx_buf_ctrl_tb;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0, hit = 1'b0, tgt = 1'b0, roll = 1'b0, cerr = 1'b0;
  logic [DW-1:0] data = '0;
  logic [1:0]    en = '0, crx = '0, covr = '0;
  logic [2*DW-1:0] bufd;
  logic [1:0]    full, ovr;
  logic          err, irq;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  can_rx_buf_ctrl #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(vld), .accept_hit_i(hit),
    .tgt_sel_i(tgt), .frame_data_i(data), .rollover_en_i(roll), .irq_en_i(en),
    .rx_clr_i(crx), .ovr_clr_i(covr), .err_clr_i(cerr), .buf_data_o(bufd),
    .rx_full_o(full), .ovr_o(ovr), .err_o(err), .irq_o(irq)
  );

  typedef struct packed {
    logic vld; logic hit; logic tgt; logic roll;
    logic [1:0] en; logic [1:0] crx; logic [1:0] covr; logic cerr;
    logic [31:0] data;
    logic [1:0] efull; logic [1:0] eovr; logic eerr; logic eirq;
    logic [31:0] ed0; logic [31:0] ed1;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // vld hit tgt roll en   crx   covr  cerr data          full  ovr   err irq d0            d1
    '{1'b1,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,32'hA1A1_0001,2'b00,2'b00,1'b0,1'b0,32'h0,        32'h0,        8'd2},  // R2 filter miss
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,32'hA1A1_0001,2'b01,2'b00,1'b0,1'b1,32'hA1A1_0001,32'h0,        8'd3},  // R3 to buf0
    '{1'b1,1'b1,1'b1,1'b0,2'b11,2'b00,2'b00,1'b0,32'hB2B2_0002,2'b11,2'b00,1'b0,1'b1,32'hA1A1_0001,32'hB2B2_0002,8'd3},  // R3 to buf1
    '{1'b0,1'b0,1'b0,1'b0,2'b11,2'b01,2'b00,1'b0,32'h0,        2'b10,2'b00,1'b0,1'b1,32'hA1A1_0001,32'hB2B2_0002,8'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b0,2'b11,2'b10,2'b00,1'b0,32'h0,        2'b00,2'b00,1'b0,1'b0,32'hA1A1_0001,32'hB2B2_0002,8'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,32'hC3C3_0003,2'b01,2'b00,1'b0,1'b1,32'hC3C3_0003,32'hB2B2_0002,8'd3},  // R3
    '{1'b1,1'b1,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,32'hD4D4_0004,2'b01,2'b01,1'b1,1'b1,32'hC3C3_0003,32'hB2B2_0002,8'd6},  // R5 R6
    '{1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,2'b01,1'b1,32'h0,        2'b01,2'b00,1'b0,1'b0,32'hC3C3_0003,32'hB2B2_0002,8'd10}, // R10 clear, R11
    '{1'b1,1'b1,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,32'hE5E5_0005,2'b11,2'b00,1'b0,1'b1,32'hC3C3_0003,32'hE5E5_0005,8'd7},  // R7
    '{1'b1,1'b1,1'b0,1'b1,2'b00,2'b00,2'b00,1'b0,32'hF6F6_0006,2'b11,2'b10,1'b1,1'b1,32'hC3C3_0003,32'hE5E5_0005,8'd8},  // R8
    '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,32'h0,        2'b11,2'b10,1'b1,1'b1,32'hC3C3_0003,32'hE5E5_0005,8'd10}, // R10 hold, R11 err only
    '{1'b1,1'b1,1'b0,1'b1,2'b00,2'b00,2'b10,1'b1,32'h1111_0007,2'b11,2'b10,1'b1,1'b1,32'hC3C3_0003,32'hE5E5_0005,8'd10}, // R10 set wins
    '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b1,32'h0,        2'b11,2'b00,1'b0,1'b0,32'hC3C3_0003,32'hE5E5_0005,8'd11}, // R11 masked
    '{1'b1,1'b1,1'b0,1'b0,2'b01,2'b01,2'b00,1'b0,32'h7777_0008,2'b11,2'b00,1'b0,1'b1,32'h7777_0008,32'hE5E5_0005,8'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,32'h8888_0009,2'b11,2'b10,1'b1,1'b1,32'h7777_0008,32'hE5E5_0005,8'd12}  // R12
  };

  task automatic chk(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic [1:0] ef, input logic [1:0] eo,
                         input logic ee, input logic ei, input logic [31:0] e0, input logic [31:0] e1);
    chk("rx_full", req, 64'(full), 64'(ef));
    chk("ovr",     req, 64'(ovr),  64'(eo));
    chk("err",     req, 64'(err),  64'(ee));
    chk("irq",     req, 64'(irq),  64'(ei));
    chk("buf0",    req, 64'(bufd[DW-1:0]),    64'(e0));
    chk("buf1",    req, 64'(bufd[2*DW-1:DW]), 64'(e1));
  endtask

  task automatic idle();
    vld = 0; hit = 0; tgt = 0; roll = 0; crx = '0; covr = '0; cerr = 0; data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    en = 2'b11;
    chk_all(1, 2'b00, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);  // R1 in reset
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(1, 2'b00, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      vld = VEC[i].vld; hit = VEC[i].hit; tgt = VEC[i].tgt; roll = VEC[i].roll;
      en = VEC[i].en; crx = VEC[i].crx; covr = VEC[i].covr; cerr = VEC[i].cerr;
      data = VEC[i].data;
      @(negedge clk);
      chk_all(int'(VEC[i].req), VEC[i].efull, VEC[i].eovr, VEC[i].eerr, VEC[i].eirq,
              VEC[i].ed0, VEC[i].ed1);
    end
    idle();

    // R12 with rollover on: buffer 1 still full, overrun stays on buffer 1
    covr = 2'b10; cerr = 1'b1; en = 2'b00;
    @(negedge clk);
    covr = '0; cerr = 0;
    vld = 1; hit = 1; tgt = 1; roll = 1; data = 32'h9999_000A;
    @(negedge clk);
    chk("ovr R12 rollover", 12, 64'(ovr), 64'(2'b10));
    chk("buf1 R12 rollover", 12, 64'(bufd[2*DW-1:DW]), 64'(32'hE5E5_0005));
    idle();

    // R2: filter miss toward empty buffer 1 changes nothing
    crx = 2'b10;
    @(negedge clk);
    crx = '0; vld = 1; hit = 0; tgt = 1; data = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("rx_full R2 miss", 2, 64'(full), 64'(2'b01));
    chk("buf1 R2 miss", 2, 64'(bufd[2*DW-1:DW]), 64'(32'hE5E5_0005));
    idle();

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk_all(1, 2'b00, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule